// File: doc/BRIEF.md
# Multi-Target Tuning Word Serial Master

This block sits on the host side of a chip and writes 8-bit control words to a small set of external tuning devices. All devices share one serial clock line and one serial data line. Each device has its own select line, and only the device whose select is high listens. A single request names the device, a 5-bit tuning state and a standby flag. The block packs these into a word, raises the chosen select line, sends the word most significant bit first, and then drops the select line. The device takes up the new word on that falling edge.

Setup, hold, clock-phase and select-off intervals are all counted in system clock cycles. Each count is derived from the system clock period by rounding up, so the device's serial timing limits hold at any system clock rate. The serial clock rests low, and data changes only while the serial clock is low, so the device can sample it on the rising edge. Devices are written one after another. Each one changes state at the end of its own transfer.

Top module: `tuner_ctl_master`

## Requirements
- R1: After reset all select lines, the serial clock and serial data are low, `req_ready_o` is high and `busy_o` is low.
- R2: Each transfer carries exactly the word {0, 0, standby, state[4:0]}. Bit 7 goes first, bit 5 is the standby flag and bits 4:0 are the state. Each bit is the data value at a rising serial clock edge.
- R3: An accepted request with index i raises only `sen_o[i]`, and the select lines stay unchanged for the whole transfer.
- R4: Serial data never changes while the serial clock is high or at its rising edge. Each high phase and each low phase of the serial clock lasts at least HALF_CYC cycles. HALF_CYC covers both the 26 MHz rate limit and the 13.2 ns data setup and hold.
- R5: At least SETUP_CYC cycles (19.2 ns) pass from a select rising to the first serial clock rise. At least HOLD_CYC cycles (19.2 ns) pass from the last serial clock rise to the select falling.
- R6: Between two transfers, all select lines stay low for at least IDLE_CYC cycles (38.4 ns).
- R7: Every transfer has exactly eight rising serial clock edges and ends with a falling edge on its select line. That falling edge is the commit.
- R8: A request is accepted only when `req_valid_i` and `req_ready_o` are both high, and `req_ready_o` is high only when idle. `busy_o` is high in the cycle after an accepted in-range request. Requests presented while busy have no effect.
- R9: An accepted request whose index is N_TGT or more raises no select line and does not make the block busy. It produces a one-cycle `err_o` pulse in the cycle after acceptance.
- R10: Whenever no select line is high, the serial clock and serial data are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken (idle) |
| req_tgt_i | input | TGT_W | Target device index |
| req_state_i | input | 5 | Tuning state to write |
| req_stby_i | input | 1 | Standby flag to write |
| busy_o | output | 1 | Transfer or select-off interval in progress |
| err_o | output | 1 | One-cycle pulse for a dropped out-of-range request |
| sclk_o | output | 1 | Shared serial clock |
| sdat_o | output | 1 | Shared serial data |
| sen_o | output | N_TGT | Per-device select lines |

## Verification
The bench sweeps every state value with both standby settings to every in-range target, back to back. A stuck, swapped or misordered word bit, or a wrong select decode, shows up in the decoded word and target at each commit. Every serial clock phase and every select edge is timed in cycles, which separates a correct divider and correct setup, hold and off intervals from ones that are one cycle short. Out-of-range indices and requests held during a busy transfer tell the error path and the idle-only acceptance apart from a block that would start a spurious transfer.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int WORD_W  = 8;
  localparam int STATE_W = 5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_HIGH, ST_LOW, ST_TRAIL, ST_GAP
  } tc_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tc_timer.sv
module tc_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/tc_shift.sv
module tc_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= data_i;
    else if (shift_i)  sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];
endmodule

// File: rtl/tc_sel_decode.sv
module tc_sel_decode #(
  parameter int N     = 3,
  parameter int IDX_W = 2
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [N-1:0]     onehot_o
);
  for (genvar g = 0; g < N; g++) begin : g_sel
    assign onehot_o[g] = (int'(idx_i) == g);
  end
endmodule

// File: rtl/tuner_ctl_master.sv
module tuner_ctl_master
  import tc_pkg::*;
#(
  parameter int N_TGT         = 3,
  parameter int TGT_W         = 2,
  parameter int CLK_PERIOD_PS = 8000,
  parameter int T_SCLK_MIN_PS = 38462,
  parameter int T_DSU_PS      = 13200,
  parameter int T_ESU_PS      = 19200,
  parameter int T_EHD_PS      = 19200,
  parameter int T_EOFF_PS     = 38400
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [TGT_W-1:0]   req_tgt_i,
  input  logic [STATE_W-1:0] req_state_i,
  input  logic               req_stby_i,
  output logic               busy_o,
  output logic               err_o,
  output logic               sclk_o,
  output logic               sdat_o,
  output logic [N_TGT-1:0]   sen_o
);
  localparam int HALF_CYC  = max2(1, max2(ceil_div(T_SCLK_MIN_PS, 2 * CLK_PERIOD_PS),
                                          ceil_div(T_DSU_PS, CLK_PERIOD_PS)));
  localparam int SETUP_CYC = max2(1, ceil_div(T_ESU_PS, CLK_PERIOD_PS));
  localparam int HOLD_CYC  = max2(1, ceil_div(T_EHD_PS, CLK_PERIOD_PS));
  localparam int IDLE_CYC  = max2(1, ceil_div(T_EOFF_PS, CLK_PERIOD_PS));
  localparam int MAX_CYC   = max2(max2(HALF_CYC, SETUP_CYC), max2(HOLD_CYC, IDLE_CYC));
  localparam int TIM_W     = $clog2(MAX_CYC + 1);
  localparam int BIT_W     = $clog2(WORD_W);

  tc_state_e          st_q, st_d;
  logic               sclk_q, sclk_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [N_TGT-1:0]   sen_q, sel_onehot;
  logic               err_q, err_d;
  logic               sen_set, sen_clr;
  logic               tm_ld, tm_done, sh_ld, sh_go, sh_msb;
  logic [TIM_W-1:0]   tm_val;
  logic               tgt_ok;

  assign tgt_ok = (int'(req_tgt_i) < N_TGT);

  tc_sel_decode #(.N(N_TGT), .IDX_W(TGT_W)) i_dec (
    .idx_i(req_tgt_i), .onehot_o(sel_onehot)
  );

  tc_timer #(.W(TIM_W)) i_tim (
    .clk_i, .rst_ni, .load_i(tm_ld), .val_i(tm_val), .done_o(tm_done)
  );

  tc_shift #(.W(WORD_W)) i_sh (
    .clk_i, .rst_ni, .load_i(sh_ld), .shift_i(sh_go),
    .data_i({2'b00, req_stby_i, req_state_i}), .msb_o(sh_msb)
  );

  always_comb begin
    st_d    = st_q;
    sclk_d  = sclk_q;
    bit_d   = bit_q;
    err_d   = 1'b0;
    sen_set = 1'b0;
    sen_clr = 1'b0;
    tm_ld   = 1'b0;
    tm_val  = '0;
    sh_ld   = 1'b0;
    sh_go   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_valid_i) begin
        if (tgt_ok) begin
          sh_ld   = 1'b1;
          sen_set = 1'b1;
          bit_d   = '0;
          tm_ld   = 1'b1;
          tm_val  = TIM_W'(SETUP_CYC - 1);
          st_d    = ST_LEAD;
        end else begin
          err_d = 1'b1;
        end
      end
      ST_LEAD, ST_LOW: if (tm_done) begin
        sclk_d = 1'b1;
        tm_ld  = 1'b1;
        tm_val = TIM_W'(HALF_CYC - 1);
        st_d   = ST_HIGH;
      end
      ST_HIGH: if (tm_done) begin
        sclk_d = 1'b0;
        sh_go  = 1'b1;     // data moves on the falling edge
        tm_ld  = 1'b1;
        if (bit_q == BIT_W'(WORD_W - 1)) begin
          tm_val = TIM_W'(HOLD_CYC - 1);
          st_d   = ST_TRAIL;
        end else begin
          bit_d  = bit_q + 1'b1;
          tm_val = TIM_W'(HALF_CYC - 1);
          st_d   = ST_LOW;
        end
      end
      ST_TRAIL: if (tm_done) begin
        sen_clr = 1'b1;    // commit edge
        tm_ld   = 1'b1;
        tm_val  = TIM_W'(IDLE_CYC - 1);
        st_d    = ST_GAP;
      end
      ST_GAP: if (tm_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      bit_q  <= '0;
      err_q  <= 1'b0;
      sen_q  <= '0;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      bit_q  <= bit_d;
      err_q  <= err_d;
      if (sen_set)      sen_q <= sel_onehot;
      else if (sen_clr) sen_q <= '0;
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign busy_o      = (st_q != ST_IDLE);
  assign err_o       = err_q;
  assign sclk_o      = sclk_q;
  assign sdat_o      = sh_msb & (|sen_q);
  assign sen_o       = sen_q;
endmodule

// File: rtl/tuner_ctl_master_chk.sv
module tuner_ctl_master_chk #(
  parameter int N_TGT     = 3,
  parameter int SETUP_CYC = 3,
  parameter int HALF_CYC  = 3,
  parameter int IDLE_CYC  = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             busy_o,
  input logic             err_o,
  input logic             sclk_o,
  input logic             sdat_o,
  input logic [N_TGT-1:0] sen_o
);
  localparam int SAT = 1000;
  int   gap_cnt, hi_cnt, ph_cnt;
  logic sclk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_cnt   <= SAT;
      hi_cnt    <= 0;
      ph_cnt    <= SAT;
      sclk_prev <= 1'b0;
    end else begin
      gap_cnt   <= (|sen_o) ? 0 : ((gap_cnt < SAT) ? gap_cnt + 1 : SAT);
      hi_cnt    <= (|sen_o) ? ((hi_cnt < SAT) ? hi_cnt + 1 : SAT) : 0;
      ph_cnt    <= (sclk_o != sclk_prev) ? 1 : ((ph_cnt < SAT) ? ph_cnt + 1 : SAT);
      sclk_prev <= sclk_o;
    end
  end

  p_sen_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sen_o));
  p_sen_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|sen_o) && $past(|sen_o)) |-> $stable(sen_o));
  p_sdat_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> $stable(sdat_o));
  p_phase_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != sclk_prev) |-> (ph_cnt >= HALF_CYC));
  p_lead_time_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> (hi_cnt >= SETUP_CYC));
  p_off_time_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|sen_o) |-> (gap_cnt >= IDLE_CYC));
  p_start_on_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|sen_o) |-> $past(req_valid_i && req_ready_o));
  p_busy_with_sen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|sen_o) |-> busy_o);
  p_err_on_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($past(req_valid_i && req_ready_o) && !(|sen_o)));
  p_lines_rest_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|sen_o) |-> (!sclk_o && !sdat_o));
endmodule

bind tuner_ctl_master tuner_ctl_master_chk #(
  .N_TGT(N_TGT), .SETUP_CYC(SETUP_CYC), .HALF_CYC(HALF_CYC), .IDLE_CYC(IDLE_CYC)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .busy_o(busy_o), .err_o(err_o), .sclk_o(sclk_o), .sdat_o(sdat_o), .sen_o(sen_o)
);

// File: tb/test_tuner_ctl_master.sv
`timescale 1ns/1ps
module test_tuner_ctl_master;
  localparam int NT   = 3;
  localparam int TW   = 2;
  localparam int CLK  = 8000;                          // ps
  localparam int HALF = (38462 + 2 * CLK - 1) / (2 * CLK);
  localparam int SETC = (19200 + CLK - 1) / CLK;
  localparam int HLDC = (19200 + CLK - 1) / CLK;
  localparam int OFFC = (38400 + CLK - 1) / CLK;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_stby = 1'b0;
  logic [TW-1:0] req_tgt = '0;
  logic [4:0] req_state = '0;
  logic req_ready_o, busy_o, err_o, sclk_o, sdat_o;
  logic [NT-1:0] sen_o;

  always #4 clk = ~clk;

  tuner_ctl_master i_tuner_ctl_master (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready_o),
    .req_tgt_i(req_tgt), .req_state_i(req_state), .req_stby_i(req_stby),
    .busy_o(busy_o), .err_o(err_o), .sclk_o(sclk_o), .sdat_o(sdat_o), .sen_o(sen_o)
  );

  int checks = 0, errors = 0;
  int exp_tgt [1024];
  int exp_word[1024];
  int wr = 0, rd = 0, cycles = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // protocol monitor
  logic [NT-1:0] p_sen = '0;
  logic p_sclk = 1'b0, p_sdat = 1'b0;
  int gap = 1000, sen_hi = 0, since_rise = 1000, ph = 1000, rises = 0;
  logic [7:0] cap = '0;

  always @(negedge clk) if (rst_n && !done) begin
    if (sen_o == '0) chk(!sclk_o && !sdat_o, "R10 lines low without select", {sclk_o, sdat_o}, 0);
    if (p_sen == '0 && sen_o != '0) begin
      chk(gap >= OFFC, "R6 select off time", gap, OFFC);
      chk($onehot(sen_o) && rd < wr && sen_o == NT'(1 << exp_tgt[rd]),
          "R3 select decode", int'(sen_o), (rd < wr) ? (1 << exp_tgt[rd]) : -1);
      rises = 0; sen_hi = 0;
    end
    if (p_sen != '0 && sen_o != '0) chk(sen_o == p_sen, "R3 select steady", int'(sen_o), int'(p_sen));
    if (sclk_o != p_sclk) begin
      chk(ph >= HALF, "R4 clock phase length", ph, HALF);
      ph = 0;
    end
    if (sclk_o && !p_sclk) begin
      chk(sdat_o == p_sdat, "R4 data still at rise", sdat_o, p_sdat);
      if (rises == 0) chk(sen_hi >= SETC, "R5 select to first rise", sen_hi, SETC);
      cap = {cap[6:0], sdat_o};
      rises++;
      since_rise = 0;
    end
    if (sclk_o && p_sclk) chk(sdat_o == p_sdat, "R4 data still while high", sdat_o, p_sdat);
    if (p_sen != '0 && sen_o == '0) begin
      chk(rises == 8, "R7 eight rises per transfer", rises, 8);
      chk(since_rise >= HLDC, "R5 last rise to select fall", since_rise, HLDC);
      chk(rd < wr && int'(cap) == exp_word[rd], "R2 word content", int'(cap),
          (rd < wr) ? exp_word[rd] : -1);
      rd++;
    end
    gap        = (sen_o == '0) ? gap + 1 : 0;
    sen_hi     = (sen_o != '0) ? sen_hi + 1 : 0;
    since_rise = since_rise + 1;
    ph         = ph + 1;
    p_sen = sen_o; p_sclk = sclk_o; p_sdat = sdat_o;
  end

  task automatic send(input int t, input int s, input bit b);
    bit ok;
    ok = (t < NT);
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid = 1'b1; req_tgt = TW'(t); req_state = 5'(s); req_stby = b;
    if (ok) begin
      exp_tgt[wr]  = t;
      exp_word[wr] = {2'b00, b, s[4:0]};
      wr++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy_o == ok, "R8 busy after accept", busy_o, ok);
    chk(err_o == !ok, "R9 error pulse after accept", err_o, !ok);
    if (!ok) begin
      chk(sen_o == '0, "R9 no select for bad index", int'(sen_o), 0);
      @(negedge clk);
      chk(err_o == 1'b0, "R9 error pulse one cycle", err_o, 0);
    end
  endtask

  initial begin : watchdog
    while (cycles < 150000 && !done) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sen_o == '0 && !sclk_o && !sdat_o, "R1 reset lines", {sen_o, sclk_o, sdat_o}, 0);
    chk(req_ready_o && !busy_o && !err_o, "R1 reset handshake", {req_ready_o, busy_o, err_o}, 4);

    // full sweep: all targets, states and standby values
    for (int t = 0; t < NT; t++)
      for (int s = 0; s < 32; s++)
        for (int b = 0; b < 2; b++)
          send(t, s, b[0]);

    // out-of-range index
    send(3, 21, 1'b1);
    send(3, 0, 1'b0);
    send(2, 9, 1'b1);
    send(3, 31, 1'b1);

    // requests held while busy are ignored
    send(1, 18, 1'b0);
    req_valid = 1'b1; req_tgt = 2'd0; req_state = 5'd7; req_stby = 1'b1;
    for (int i = 0; i < 20; i++) begin
      chk(!req_ready_o, "R8 not ready while busy", req_ready_o, 0);
      @(negedge clk);
    end
    req_valid = 1'b0;

    while (busy_o) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(rd == wr, "R7 R8 commit count", rd, wr);
    chk(sen_o == '0 && req_ready_o, "R8 back to idle", int'(sen_o), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule